// File: doc/BRIEF.md
# Main Clock Frequency Failure Monitor

This block watches a main clock that may stop or slow down. It measures that clock against a free-running reference clock. The block runs entirely in the reference domain. It splits time into windows of `WIN_CYC` reference cycles and looks for rising edges of the monitored clock. If a whole window passes with no rising edge, the block raises a fault and drives an active-low fault line low. The fault stays set for as long as the monitored clock stays stopped or too slow.

When the monitored clock returns, the block counts its rising edges. It releases the fault after `REL_EDGES` edges, which is 16 by default. A window with no edges during recovery restarts that count. The block keeps running during low-power halt and idle states, so a clock that stops in those states is reported. With a 1 ms window, the block always trips at 10 Hz and never trips at 5 kHz or faster.

Monitoring is on after reset. The first watchdog service can turn it off, and that choice is then fixed until the next reset. The fault line is ANDed with the watchdog error line onto one shared active-low alarm output.

Top module: `clk_fail_mon`

## Requirements
- R1: While reset is asserted, and before the first window ends after reset, `mon_fault_n` is 1.
- R2: A monitored clock with a period of at most `WIN_CYC/2` reference cycles never drives `mon_fault_n` low.
- R3: When a full window passes with no monitored rising edge and monitoring is enabled, `mon_fault_n` goes low at the end of that window. A stopped or very slow clock (period above `2*WIN_CYC`) is therefore flagged.
- R4: `mon_fault_n` stays low for as long as the monitored clock stays stopped, across any number of windows.
- R5: After the clock restarts, `mon_fault_n` stays low through the first `REL_EDGES-1` rising edges. It goes high within `SYNC_STAGES+2` reference cycles after rising edge number `REL_EDGES`, which is 16 by default.
- R6: Recovery edges are counted across window boundaries, as long as each window holds at least one edge. A window with no edges clears the recovery count, so a full new run of `REL_EDGES` edges is then needed.
- R7: Monitoring is enabled after reset. On the first `svc_stb` pulse after reset, the enable takes the value of `svc_mon_en`. Later pulses are ignored until the next reset.
- R8: While monitoring is disabled, `mon_fault_n` is 1, and an active fault clears within two reference cycles of the disabling service.
- R9: `alarm_n` equals `mon_fault_n AND wd_err_n` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; all state is clocked by it |
| rst_n | input | 1 | Active-low reset |
| mon_clk | input | 1 | Monitored main clock, asynchronous to ref_clk |
| svc_stb | input | 1 | One-cycle pulse marking a watchdog service |
| svc_mon_en | input | 1 | Monitor enable value carried by the service |
| wd_err_n | input | 1 | Active-low watchdog error from the neighbouring watchdog |
| mon_fault_n | output | 1 | Active-low clock fault from this monitor |
| alarm_n | output | 1 | Shared active-low alarm: fault AND watchdog error |

## Verification
The monitored clock is generated inside the bench on falling reference edges, and every output is sampled on falling edges. A monitored rising edge passes through the two-flop synchroniser and then one fault register. A release is therefore due 2.5 reference cycles after the edge: the bench checks "still low" three cycles after edge 15 and "high" five cycles after edge 16. Trip checks run over several whole windows and record whether any low sample is seen, so the exact cycle of the window boundary never decides a result. The alarm output is combinational, so it is checked in the same cycle that its inputs are set.

// File: rtl/clk_mon_pkg.sv
package clk_mon_pkg;
   typedef enum logic {
      MON_OK    = 1'b0,
      MON_FAULT = 1'b1
   } mon_state_e;
endpackage

// File: rtl/cm_edge_sync.sv
module cm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cm_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   // pipe[0..STAGES-1] is the synchroniser, pipe[STAGES] holds the previous level
   logic [STAGES:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-1:0], async_in};
   end

   assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];

   // R3
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/cm_en_latch.sv
module cm_en_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic svc_stb,
   input  logic svc_en,
   output logic en_o
);
   logic locked_q;
   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         en_q     <= 1'b1;
      end else if (svc_stb && !locked_q) begin
         locked_q <= 1'b1;
         en_q     <= svc_en;
      end
   end

   assign en_o = en_q;

   // R7
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> (locked_q && $stable(en_q)));
endmodule

// File: rtl/cm_window.sv
module cm_window
   import clk_mon_pkg::*;
#(
   parameter int WIN_CYC   = 50000,
   parameter int REL_EDGES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic rise,
   output logic fault_o
);
   localparam int WW = $clog2(WIN_CYC);
   localparam int RW = $clog2(REL_EDGES + 1);
   localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYC - 1);
   localparam logic [RW-1:0] REL_LAST = RW'(REL_EDGES - 1);

   generate
      if (WIN_CYC < 4) begin : g_bad_win
         $error("cm_window: WIN_CYC must be at least 4");
      end
      if (REL_EDGES < 2) begin : g_bad_rel
         $error("cm_window: REL_EDGES must be at least 2");
      end
   endgenerate

   logic [WW-1:0] win_cnt;
   logic          seen_q;
   logic [RW-1:0] rec_cnt;
   mon_state_e    state_q;
   logic          last;
   logic          empty;

   assign last  = (win_cnt == WIN_LAST);
   assign empty = last && !(seen_q || rise);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt <= '0;
         seen_q  <= 1'b0;
      end else begin
         win_cnt <= last ? '0 : win_cnt + 1'b1;
         seen_q  <= last ? 1'b0 : (seen_q | rise);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MON_OK;
         rec_cnt <= '0;
      end else if (!en) begin
         state_q <= MON_OK;
         rec_cnt <= '0;
      end else begin
         case (state_q)
            MON_OK: begin
               rec_cnt <= '0;
               if (empty) state_q <= MON_FAULT;
            end
            default: begin
               if (rise && rec_cnt == REL_LAST) begin
                  state_q <= MON_OK;
                  rec_cnt <= '0;
               end else if (empty) begin
                  rec_cnt <= '0;
               end else if (rise) begin
                  rec_cnt <= rec_cnt + 1'b1;
               end
            end
         endcase
      end
   end

   assign fault_o = (state_q == MON_FAULT);

   // R3
   fault_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_o) |-> ($past(win_cnt) == WIN_LAST));
   // R5
   release_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_o) |-> ($past(rec_cnt) == REL_LAST || !$past(en)));
   // R6
   rec_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_cnt <= REL_LAST);
   // R1
   win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_cnt <= WIN_LAST);
endmodule

// File: rtl/clk_fail_mon.sv
module clk_fail_mon #(
   parameter int WIN_CYC     = 50000,
   parameter int REL_EDGES   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic mon_clk,
   input  logic svc_stb,
   input  logic svc_mon_en,
   input  logic wd_err_n,
   output logic mon_fault_n,
   output logic alarm_n
);
   logic mon_rise;
   logic mon_en;
   logic fault;

   cm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (ref_clk),
      .rst_n    (rst_n),
      .async_in (mon_clk),
      .rise_o   (mon_rise)
   );

   cm_en_latch u_en (
      .clk     (ref_clk),
      .rst_n   (rst_n),
      .svc_stb (svc_stb),
      .svc_en  (svc_mon_en),
      .en_o    (mon_en)
   );

   cm_window #(.WIN_CYC(WIN_CYC), .REL_EDGES(REL_EDGES)) u_win (
      .clk     (ref_clk),
      .rst_n   (rst_n),
      .en      (mon_en),
      .rise    (mon_rise),
      .fault_o (fault)
   );

   assign mon_fault_n = ~fault;
   assign alarm_n     = mon_fault_n & wd_err_n;

   // R8
   disabled_quiet_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !mon_en |=> mon_fault_n);
   // R9
   alarm_merge_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !mon_fault_n |-> !alarm_n);
endmodule

// File: tb/clk_fail_mon_test.sv
module clk_fail_mon_test;
   localparam int WIN = 64;
   localparam int REL = 16;

   logic ref_clk = 1'b0;
   logic rst_n = 1'b0;
   logic mon_clk = 1'b0;
   logic svc_stb = 1'b0;
   logic svc_mon_en = 1'b1;
   logic wd_err_n = 1'b1;
   logic mon_fault_n;
   logic alarm_n;

   int n_checks = 0;
   int n_fail = 0;
   int half = 0;
   int ph = 0;
   int rise_cnt = 0;
   logic saw;

   clk_fail_mon #(.WIN_CYC(WIN), .REL_EDGES(REL), .SYNC_STAGES(2)) uut (
      .ref_clk(ref_clk), .rst_n(rst_n), .mon_clk(mon_clk),
      .svc_stb(svc_stb), .svc_mon_en(svc_mon_en), .wd_err_n(wd_err_n),
      .mon_fault_n(mon_fault_n), .alarm_n(alarm_n)
   );

   always #10 ref_clk = ~ref_clk;

   // monitored clock: toggles every `half` reference cycles, on falling edges
   always @(negedge ref_clk) begin
      if (half != 0) begin
         ph = ph + 1;
         if (ph >= half) begin
            ph = 0;
            mon_clk = ~mon_clk;
            if (mon_clk) rise_cnt = rise_cnt + 1;
         end
      end
   end

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic set_half(input int h);
      @(posedge ref_clk);
      half = h;
      ph = 0;
      rise_cnt = 0;
   endtask

   task automatic do_reset();
      @(negedge ref_clk);
      rst_n = 1'b0;
      repeat (3) @(negedge ref_clk);
      rst_n = 1'b1;
   endtask

   task automatic watch(input int cyc);
      saw = 1'b0;
      repeat (cyc) begin
         @(negedge ref_clk);
         if (!mon_fault_n) saw = 1'b1;
      end
   endtask

   task automatic service(input logic en);
      @(negedge ref_clk);
      svc_stb = 1'b1;
      svc_mon_en = en;
      @(negedge ref_clk);
      svc_stb = 1'b0;
   endtask

   task automatic release_test(input string req);
      wait (rise_cnt == REL - 1);
      repeat (3) @(negedge ref_clk);
      check(req, mon_fault_n, 1'b0);
      wait (rise_cnt == REL);
      repeat (5) @(negedge ref_clk);
      check(req, mon_fault_n, 1'b1);
   endtask

   initial begin
      #(20 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (2) @(negedge ref_clk);
      check("R1", mon_fault_n, 1'b1);
      check("R9", alarm_n, 1'b1);
      rst_n = 1'b1;
      repeat (WIN / 2) @(negedge ref_clk);
      check("R1", mon_fault_n, 1'b1);

      // R2 sweep of fast clocks: never flagged
      for (int h = 2; h <= WIN / 4; h++) begin
         set_half(h);
         do_reset();
         watch(6 * WIN);
         check("R2", saw, 1'b0);
      end

      // R3 sweep of very slow clocks: flagged
      for (int k = 0; k < 3; k++) begin
         set_half(WIN + 2 + k * 33);
         do_reset();
         watch(4 * (WIN + 2 + k * 33) + 2 * WIN);
         check("R3", saw, 1'b1);
      end

      // R3 and R4: stopped clock trips, then holds
      set_half(0);
      mon_clk = 1'b0;
      do_reset();
      repeat (2 * WIN + 4) @(negedge ref_clk);
      check("R3", mon_fault_n, 1'b0);
      saw = 1'b0;
      repeat (10 * WIN) begin
         @(negedge ref_clk);
         if (mon_fault_n) saw = 1'b1;
      end
      check("R4", saw, 1'b0);

      // R5 fast restart
      set_half(2);
      release_test("R5");

      // R6 interrupted recovery
      set_half(0);
      repeat (2 * WIN + 4) @(negedge ref_clk);
      check("R3", mon_fault_n, 1'b0);
      set_half(2);
      wait (rise_cnt == 10);
      set_half(0);
      repeat (3 * WIN) @(negedge ref_clk);
      check("R6", mon_fault_n, 1'b0);
      set_half(2);
      release_test("R6");

      // R6 slow clock: recovery spans several windows
      set_half(0);
      repeat (2 * WIN + 4) @(negedge ref_clk);
      check("R6", mon_fault_n, 1'b0);
      set_half(20);
      release_test("R6");
      watch(6 * WIN);
      check("R2", saw, 1'b0);

      // R7 and R8 enable handling
      set_half(0);
      mon_clk = 1'b0;
      do_reset();
      repeat (2 * WIN + 4) @(negedge ref_clk);
      check("R7", mon_fault_n, 1'b0);
      // R9 with fault active
      wd_err_n = 1'b1;
      #1 check("R9", alarm_n, 1'b0);
      wd_err_n = 1'b0;
      #1 check("R9", alarm_n, 1'b0);
      wd_err_n = 1'b1;
      service(1'b0);
      @(negedge ref_clk);
      check("R8", mon_fault_n, 1'b1);
      service(1'b1);
      watch(3 * WIN);
      check("R7", saw, 1'b0);
      check("R8", mon_fault_n, 1'b1);
      // R9 with no fault
      wd_err_n = 1'b0;
      #1 check("R9", alarm_n, 1'b0);
      wd_err_n = 1'b1;
      #1 check("R9", alarm_n, 1'b1);

      do_reset();
      service(1'b1);
      repeat (2 * WIN + 4) @(negedge ref_clk);
      check("R7", mon_fault_n, 1'b0);
      service(1'b0);
      repeat (3) @(negedge ref_clk);
      check("R7", mon_fault_n, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule